// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block decides when a battery-backed byte-wide memory may be accessed. Three supply-level flags, already digitised by analog comparators, say whether the supply is above the upper deselect threshold, below the lower deselect threshold, or below the battery switchover level. The block passes these flags through two-flop synchronisers and sorts them into one supply class. A four-state machine then drives the memory-deselect, write-inhibit, data-output tristate and battery-select outputs. It also reports its state on a status port.

The states are NORMAL (accesses allowed), DESELECT (supply in the deselect window or below it, memory fenced off), BATTERY (below switchover, memory fenced off and running from the cell) and RECOVER (supply good again, lockout interval running). The transitions are:
- NORMAL to DESELECT on a window reading.
- NORMAL to DESELECT or BATTERY after a configurable lag on a fast fall that skips the window.
- DESELECT to BATTERY on a switchover reading.
- BATTERY to DESELECT when the supply rises above switchover.
- DESELECT or BATTERY to RECOVER on a good reading.
- RECOVER back to DESELECT or BATTERY on any renewed drop.
- RECOVER to NORMAL once the interval has elapsed and no write strobe pair is held.

The lockout length is a cycle count. At a 10 MHz clock, 400,000 cycles gives 40 ms.

Top module: `pwrsup_guard`

## Requirements
- R1: Reset puts the block in DESELECT. The status encoding is NORMAL=0, DESELECT=1, BATTERY=2, RECOVER=3. In DESELECT, `mem_desel`, `wr_inhibit` and `dq_hiz` are 1 and `bat_sel` is 0. In NORMAL all four are 0.
- R2: Flags are active high: above-upper=1, below-lower=0 and below-switchover=0 means good; all three at 0 means the window. A window reading in NORMAL reaches DESELECT on the third rising edge after the flags change (two synchroniser stages plus the state register).
- R3: A switchover reading (below-upper, below-lower=1, below-switchover=1) in DESELECT moves to BATTERY. In BATTERY all four outputs are 1. When below-switchover falls back to 0 with below-lower still 1, the block returns to DESELECT and `bat_sel` goes to 0.
- R4: A good reading in DESELECT or BATTERY enters RECOVER. The block stays in RECOVER, fully protected, for exactly REC_CYC cycles before reaching NORMAL.
- R5: A window or below-lower reading during RECOVER returns the block to DESELECT. The next recovery runs the full REC_CYC cycles again.
- R6: In DESELECT and BATTERY, `ce_n` and `we_n` have no effect on any output.
- R7: If `ce_n` and `we_n` are both held low when the interval ends, the block stays in RECOVER. It reaches NORMAL on the third rising edge after either strobe is released.
- R8: A direct change from good to below-lower (fast fall) leaves NORMAL only after LAG_CYC further cycles. The block is then in DESELECT, or in BATTERY if below-switchover is also 1. The state changes on edge LAG_CYC+3 after the flags change.
- R9: Contradictory flag sets (above-upper with either low flag, or below-switchover without below-lower) count as a window reading. They deselect at once from NORMAL and never select the battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_above_hi | input | 1 | Supply above upper deselect threshold |
| sup_below_lo | input | 1 | Supply below lower deselect threshold |
| sup_below_bat | input | 1 | Supply below battery switchover level |
| ce_n | input | 1 | Memory chip-enable strobe, active low |
| we_n | input | 1 | Memory write-enable strobe, active low |
| mem_desel | output | 1 | Deselect the memory |
| wr_inhibit | output | 1 | Block writes |
| dq_hiz | output | 1 | Request high-impedance data outputs |
| bat_sel | output | 1 | Power the memory from the battery |
| sup_status | output | 2 | Current state code |

## Verification
The bench builds the block with REC_CYC=20 and LAG_CYC=5 in place of the real-time counts. With these values the full lockout interval, its restart after a renewed drop, and the fast-fall lag can each be measured to the exact cycle, and each measurement fits in a few dozen clocks. The bench also holds a write across the end of recovery and applies every contradictory flag set, so the strobe hold-off and the safe classification are reached in a short run.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_DESELECT = 2'd1,
        ST_BATTERY  = 2'd2,
        ST_RECOVER  = 2'd3
    } sup_state_e;

    typedef enum logic [1:0] {
        SUP_GOOD   = 2'd0,
        SUP_WINDOW = 2'd1,
        SUP_LOW    = 2'd2,
        SUP_BATT   = 2'd3
    } sup_class_e;

    typedef struct packed {
        logic desel;
        logic inhibit;
        logic hiz;
        logic bat;
    } guard_out_t;

endpackage

// File: rtl/pwrsup_sync.sv
module pwrsup_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("pwrsup_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pwrsup_classify.sv
module pwrsup_classify
    import pwrsup_pkg::*;
(
    input  logic       above_hi,
    input  logic       below_lo,
    input  logic       below_bat,
    output sup_class_e cls
);

    always_comb begin
        unique case ({above_hi, below_lo, below_bat})
            3'b100:  cls = SUP_GOOD;
            3'b000:  cls = SUP_WINDOW;
            3'b010:  cls = SUP_LOW;
            3'b011:  cls = SUP_BATT;
            default: cls = SUP_WINDOW;
        endcase
    end

endmodule

// File: rtl/pwrsup_fsm.sv
module pwrsup_fsm
    import pwrsup_pkg::*;
#(
    parameter int unsigned REC_CYC = 400_000,
    parameter int unsigned LAG_CYC = 2_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  sup_class_e cls,
    input  logic       wr_busy,
    output sup_state_e state,
    output guard_out_t gout
);

    localparam int unsigned REC_W = $clog2(REC_CYC + 1);
    localparam int unsigned LAG_W = $clog2(LAG_CYC + 2);

    sup_state_e       nxt;
    logic [REC_W-1:0] rec_cnt;
    logic [LAG_W-1:0] lag_cnt;
    logic             rec_done;
    logic             lag_done;
    logic             fast;

    assign rec_done = (rec_cnt == REC_W'(REC_CYC - 1));
    assign lag_done = (lag_cnt == LAG_W'(LAG_CYC));
    assign fast     = (cls == SUP_LOW) || (cls == SUP_BATT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL: begin
                if (cls == SUP_WINDOW)               nxt = ST_DESELECT;
                else if (cls == SUP_LOW && lag_done)  nxt = ST_DESELECT;
                else if (cls == SUP_BATT && lag_done) nxt = ST_BATTERY;
            end
            ST_DESELECT: begin
                if (cls == SUP_BATT)      nxt = ST_BATTERY;
                else if (cls == SUP_GOOD) nxt = ST_RECOVER;
            end
            ST_BATTERY: begin
                if (cls == SUP_GOOD)      nxt = ST_RECOVER;
                else if (cls != SUP_BATT) nxt = ST_DESELECT;
            end
            ST_RECOVER: begin
                if (cls == SUP_BATT)                       nxt = ST_BATTERY;
                else if (cls != SUP_GOOD)                  nxt = ST_DESELECT;
                else if (rec_done && !wr_busy)             nxt = ST_NORMAL;
            end
            default: nxt = ST_DESELECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DESELECT;
            rec_cnt <= '0;
            lag_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_RECOVER && cls == SUP_GOOD) begin
                if (!rec_done) rec_cnt <= rec_cnt + 1'b1;
            end else begin
                rec_cnt <= '0;
            end
            if (state == ST_NORMAL && fast && !lag_done) begin
                lag_cnt <= lag_cnt + 1'b1;
            end else if (!(state == ST_NORMAL && fast)) begin
                lag_cnt <= '0;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_NORMAL:   gout = '{desel: 1'b0, inhibit: 1'b0, hiz: 1'b0, bat: 1'b0};
            ST_DESELECT: gout = '{desel: 1'b1, inhibit: 1'b1, hiz: 1'b1, bat: 1'b0};
            ST_BATTERY:  gout = '{desel: 1'b1, inhibit: 1'b1, hiz: 1'b1, bat: 1'b1};
            ST_RECOVER:  gout = '{desel: 1'b1, inhibit: 1'b1, hiz: 1'b1, bat: 1'b0};
            default:     gout = '{desel: 1'b1, inhibit: 1'b1, hiz: 1'b1, bat: 1'b0};
        endcase
    end

    // R2: window reading leaves NORMAL on the next edge
    assert_window_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && cls == SUP_WINDOW) |=> state == ST_DESELECT);

    // R3: switchover reading from DESELECT selects battery
    assert_batt_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESELECT && cls == SUP_BATT) |=> (state == ST_BATTERY && gout.bat));

    // R3: battery released once the switchover flag clears
    assert_bat_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BATTERY && cls != SUP_BATT) |=> !gout.bat);

    // R4: NORMAL is reached from RECOVER only after the full interval
    assert_recover_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && $past(state) == ST_RECOVER) |-> $past(rec_done));

    // R5: a renewed drop during RECOVER restarts from DESELECT
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && (cls == SUP_WINDOW || cls == SUP_LOW))
        |=> (state == ST_DESELECT && rec_cnt == '0));

    // R7: a held write pair keeps the lockout in force
    assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && wr_busy) |=> state != ST_NORMAL);

    // R8: the fast-fall lag never exceeds its bound
    assert_lag_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && fast && lag_done) |=> state != ST_NORMAL);

endmodule

// File: rtl/pwrsup_guard.sv
module pwrsup_guard
    import pwrsup_pkg::*;
#(
    parameter int unsigned REC_CYC     = 400_000,
    parameter int unsigned LAG_CYC     = 2_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_above_hi,
    input  logic       sup_below_lo,
    input  logic       sup_below_bat,
    input  logic       ce_n,
    input  logic       we_n,
    output logic       mem_desel,
    output logic       wr_inhibit,
    output logic       dq_hiz,
    output logic       bat_sel,
    output logic [1:0] sup_status
);

    logic [2:0] flags_s;
    logic [1:0] strb_s;
    sup_class_e cls;
    sup_state_e state;
    guard_out_t gout;
    logic       wr_busy;

    pwrsup_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sup_above_hi, sup_below_lo, sup_below_bat}),
        .q     (flags_s)
    );

    pwrsup_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n}),
        .q     (strb_s)
    );

    assign wr_busy = !strb_s[1] && !strb_s[0];

    pwrsup_classify u_cls (
        .above_hi  (flags_s[2]),
        .below_lo  (flags_s[1]),
        .below_bat (flags_s[0]),
        .cls       (cls)
    );

    pwrsup_fsm #(.REC_CYC(REC_CYC), .LAG_CYC(LAG_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls     (cls),
        .wr_busy (wr_busy),
        .state   (state),
        .gout    (gout)
    );

    assign mem_desel  = gout.desel;
    assign wr_inhibit = gout.inhibit;
    assign dq_hiz     = gout.hiz;
    assign bat_sel    = gout.bat;
    assign sup_status = state;

endmodule

// File: tb/pwrsup_guard_bench.sv
module pwrsup_guard_bench;

    localparam int REC = 20;
    localparam int LAG = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b1, bt = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1;
    logic mem_desel, wr_inhibit, dq_hiz, bat_sel;
    logic [1:0] sup_status;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        string      req;
        logic [5:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    pwrsup_guard #(.REC_CYC(REC), .LAG_CYC(LAG)) u_pwrsup_guard (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi(hi), .sup_below_lo(lo), .sup_below_bat(bt),
        .ce_n(ce_n), .we_n(we_n),
        .mem_desel(mem_desel), .wr_inhibit(wr_inhibit), .dq_hiz(dq_hiz),
        .bat_sel(bat_sel), .sup_status(sup_status)
    );

    function automatic logic [5:0] exp_of(input logic [1:0] code);
        case (code)
            2'd0:    return {code, 4'b0000};
            2'd2:    return {code, 4'b1111};
            default: return {code, 4'b1110};
        endcase
    endfunction

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [5:0] act;
            it  = sb_q.pop_front();
            act = {sup_status, mem_desel, wr_inhibit, dq_hiz, bat_sel};
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_state(input string req, input logic [1:0] code);
        exp_item_t it;
        @(posedge clk);
        it.req = req;
        it.exp = exp_of(code);
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic check_num(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic h, input logic l, input logic b);
        @(negedge clk);
        hi = h; lo = l; bt = b;
    endtask

    task automatic count_in(input logic [1:0] code, output int n);
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            if (sup_status != code) break;
            n++;
        end
    endtask

    task automatic wait_for(input logic [1:0] code);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (sup_status == code) break;
        end
    endtask

    task automatic go_normal();
        set_flags(1'b1, 1'b0, 1'b0);
        wait_for(2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_state("R1 reset state", 2'd1);

        // R4: power-up recovery length
        set_flags(1'b1, 1'b0, 1'b0);
        wait_for(2'd3);
        count_in(2'd3, n);
        check_num("R4 recover length", n + 1, REC);
        expect_state("R4 normal after recover", 2'd0);

        // R2: window reading
        set_flags(1'b0, 1'b0, 1'b0);
        count_in(2'd0, n);
        check_num("R2 window latency", n, 2);
        expect_state("R2 deselect", 2'd1);

        // R6: strobes ignored in DESELECT
        ce_n = 1'b0; we_n = 1'b0;
        repeat (3) expect_state("R6 strobes ignored deselect", 2'd1);
        ce_n = 1'b1; we_n = 1'b1;
        expect_state("R6 strobes released deselect", 2'd1);

        // R3: battery entry and release
        set_flags(1'b0, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        expect_state("R3 battery select", 2'd2);
        ce_n = 1'b0;
        expect_state("R6 ce ignored battery", 2'd2);
        we_n = 1'b0;
        expect_state("R6 we ignored battery", 2'd2);
        ce_n = 1'b1; we_n = 1'b1;
        set_flags(1'b0, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        expect_state("R3 battery released", 2'd1);

        // R5: renewed drop restarts recovery
        set_flags(1'b1, 1'b0, 1'b0);
        wait_for(2'd3);
        repeat (10) @(negedge clk);
        expect_state("R5 mid recover", 2'd3);
        set_flags(1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        expect_state("R5 back to deselect", 2'd1);
        set_flags(1'b1, 1'b0, 1'b0);
        wait_for(2'd3);
        count_in(2'd3, n);
        check_num("R5 full restart length", n + 1, REC);

        // R7: write held across end of recovery
        set_flags(1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        set_flags(1'b1, 1'b0, 1'b0);
        wait_for(2'd3);
        repeat (REC + 10) @(negedge clk);
        expect_state("R7 held in recover", 2'd3);
        @(negedge clk);
        we_n = 1'b1;
        count_in(2'd3, n);
        check_num("R7 release latency", n, 2);
        ce_n = 1'b1;
        expect_state("R7 normal after release", 2'd0);

        // R8: fast fall straight below lower threshold
        set_flags(1'b0, 1'b1, 1'b0);
        count_in(2'd0, n);
        check_num("R8 lag to deselect", n, LAG + 2);
        expect_state("R8 deselect after lag", 2'd1);
        go_normal();
        set_flags(1'b0, 1'b1, 1'b1);
        count_in(2'd0, n);
        check_num("R8 lag to battery", n, LAG + 2);
        expect_state("R8 battery after lag", 2'd2);

        // R9: contradictory flags
        go_normal();
        set_flags(1'b1, 1'b1, 1'b0);
        count_in(2'd0, n);
        check_num("R9 contradiction latency", n, 2);
        expect_state("R9 contradiction deselect", 2'd1);
        set_flags(1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        expect_state("R9 no battery on bat-only flag", 2'd1);
        set_flags(1'b1, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        expect_state("R9 all flags set", 2'd1);

        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule